// File: doc/BRIEF.md
# Move-Triggered Pipelined Arithmetic Unit

This block is a function unit for a coprocessor in which every operation is a data move. Several shared 32-bit buses run past the unit. A move into the operand register only stores a value. A move into the trigger register stores the second value and the opcode, and that move starts an operation. The operation passes through a fixed three-register pipeline that never stalls. The outcome is placed in a result register, and on request it is driven onto one chosen bus.

Each operation takes the operand-register value and the trigger data, and it performs add, subtract, AND, OR or XOR on them. A new trigger may arrive in every cycle. Because nothing holds the pipeline, a newer result replaces an older one in the result register whether or not the older one was read. A valid flag tells the scheduler whether the result register holds a result that has not yet been read.

Top module: `move_trig_unit`

## Requirements
- R1: After reset, every `bus_out` lane is zero and `res_valid` is 0.
- R2: When `opnd_ld` is high, the operand register takes the bus that `opnd_sel` picks. A write to the operand register alone never changes `res_valid` or any value later read from the unit.
- R3: When `trig_ld` is high in cycle k, the unit captures the bus that `trig_sel` picks, together with `opcode`. The result is in the result register for a read requested in cycle k+3. A read requested in cycle k+2 still returns the previous contents.
- R4: If `opnd_ld` and `trig_ld` are both high in the same cycle, the operation uses the operand value written in that cycle.
- R5: The opcode values, with O as the operand register and T as the trigger data, computed modulo 2^32: 0 gives O+T, 1 gives O-T, 2 gives O AND T, 3 gives O OR T, 4 gives O XOR T. The values 5, 6 and 7 give zero.
- R6: A trigger is accepted in every cycle, back to back. Each result lands exactly three cycles after its own trigger, and a later result replaces the result register even when the earlier one was not read.
- R7: When `rd_req` is high in a cycle, the next cycle shows the result register on lane `rd_sel` of `bus_out`, and every other lane is zero. Lane i occupies bits [32i+31:32i]. When `rd_req` is low, every lane is zero in the next cycle.
- R8: `res_valid` is set from the clock edge where a result lands. It is cleared by a read at an edge where no result lands. When a read and a landing happen at the same edge, the read returns the old contents and `res_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 128 | The four shared data buses, lane i at bits [32i+31:32i] |
| opnd_sel | input | 2 | Chooses the bus that is loaded into the operand register |
| opnd_ld | input | 1 | Load strobe for the operand register |
| trig_sel | input | 2 | Chooses the bus that is loaded into the trigger register |
| trig_ld | input | 1 | Load strobe for the trigger register; starts an operation |
| opcode | input | 3 | Operation code, captured with the trigger |
| rd_req | input | 1 | Request to drive the result register onto a bus |
| rd_sel | input | 2 | Chooses the bus that the result is driven onto |
| bus_out | output | 128 | Registered drive toward the buses; the chosen lane or all zero |
| res_valid | output | 1 | The result register holds a result that has not been read |

## Verification
Faults inside the unit show up at the ports as follows:
- **Pipeline stage slip.** A missing or extra stage moves a result one cycle early or late. The reads made exactly in cycle k+2 and in cycle k+3 separate the correct timing from both faults.
- **Stale operand value.** If the operand path is wrong, the same-cycle operand-and-trigger case returns the old operand's arithmetic. That wrong value appears on the bus one cycle after the read.
- **Wrong flag or lane.** A corrupted valid flag, or a result driven onto the wrong lane, is visible at the very next edge.

The bench compares every cycle against a model. It uses random moves mixed with directed overwrite and same-edge read-and-land cases.

// File: rtl/mtu_pkg.sv
package mtu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;
endpackage

// File: rtl/fu_bus_pick.sv
module fu_bus_pick #(
  parameter int DATA_W  = 32,
  parameter int NUM_BUS = 4,
  localparam int SEL_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic [NUM_BUS*DATA_W-1:0] buses,
  input  logic [SEL_W-1:0]          sel,
  output logic [DATA_W-1:0]         word
);
  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_BUS; i++) begin
      if (sel == SEL_W'(i)) word = buses[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/fu_alu.sv
module fu_alu #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  import mtu_pkg::*;
  always_comb begin
    case (op_e'(op))
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/fu_delay_line.sv
module fu_delay_line #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [DATA_W-1:0] in_d,
  output logic              out_v,
  output logic [DATA_W-1:0] out_d
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign out_v = in_v;
      assign out_d = in_d;
    end else begin : g_regs
      logic              v_q [DEPTH];
      logic [DATA_W-1:0] d_q [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) v_q[i] <= 1'b0;
        end else begin
          v_q[0] <= in_v;
          for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
        end
        d_q[0] <= in_d;
        for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
      end
      assign out_v = v_q[DEPTH-1];
      assign out_d = d_q[DEPTH-1];

      // R6
      entry_advance_chk: assert property (@(posedge clk) disable iff (rst)
        in_v |=> v_q[0]);
    end
  endgenerate
endmodule

// File: rtl/fu_result_port.sv
module fu_result_port #(
  parameter int DATA_W  = 32,
  parameter int NUM_BUS = 4,
  localparam int SEL_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      land,
  input  logic [DATA_W-1:0]         land_d,
  input  logic                      rd_req,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [NUM_BUS*DATA_W-1:0] bus_out,
  output logic                      res_valid
);
  logic [DATA_W-1:0]         r_q;
  logic                      v_q;
  logic [NUM_BUS*DATA_W-1:0] drv_q;
  logic [NUM_BUS-1:0]        lane_nz;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_q   <= '0;
      v_q   <= 1'b0;
      drv_q <= '0;
    end else begin
      if (land) r_q <= land_d;
      if (land) v_q <= 1'b1;
      else if (rd_req) v_q <= 1'b0;
      for (int i = 0; i < NUM_BUS; i++) begin
        if (rd_req && rd_sel == SEL_W'(i)) drv_q[i*DATA_W +: DATA_W] <= r_q;
        else drv_q[i*DATA_W +: DATA_W] <= '0;
      end
    end
  end

  assign bus_out   = drv_q;
  assign res_valid = v_q;

  always_comb begin
    for (int i = 0; i < NUM_BUS; i++) lane_nz[i] = |drv_q[i*DATA_W +: DATA_W];
  end

  // R7
  single_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_nz) <= 1);
  // R7
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (bus_out == '0));
  // R8
  land_sets_chk: assert property (@(posedge clk) disable iff (rst)
    land |=> res_valid);
  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !land) |=> !res_valid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!land && !rd_req) |=> ($stable(r_q) && $stable(res_valid)));
endmodule

// File: rtl/move_trig_unit.sv
module move_trig_unit #(
  parameter int DATA_W  = 32,
  parameter int NUM_BUS = 4,
  parameter int LAT     = 3,
  localparam int SEL_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int DLY    = LAT - 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BUS*DATA_W-1:0] bus_in,
  input  logic [SEL_W-1:0]          opnd_sel,
  input  logic                      opnd_ld,
  input  logic [SEL_W-1:0]          trig_sel,
  input  logic                      trig_ld,
  input  logic [2:0]                opcode,
  input  logic                      rd_req,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [NUM_BUS*DATA_W-1:0] bus_out,
  output logic                      res_valid
);
  logic [DATA_W-1:0] opnd_word, trig_word, opnd_q, opnd_now, alu_y;
  logic              s0_v;
  logic [DATA_W-1:0] s0_a, s0_b;
  logic [2:0]        s0_op;
  logic              land_v;
  logic [DATA_W-1:0] land_d;

  fu_bus_pick #(.DATA_W(DATA_W), .NUM_BUS(NUM_BUS)) u_pick_o (
    .buses(bus_in), .sel(opnd_sel), .word(opnd_word));
  fu_bus_pick #(.DATA_W(DATA_W), .NUM_BUS(NUM_BUS)) u_pick_t (
    .buses(bus_in), .sel(trig_sel), .word(trig_word));

  // a same-cycle operand write feeds the trigger directly
  assign opnd_now = opnd_ld ? opnd_word : opnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_q <= '0;
      s0_v   <= 1'b0;
      s0_a   <= '0;
      s0_b   <= '0;
      s0_op  <= '0;
    end else begin
      if (opnd_ld) opnd_q <= opnd_word;
      s0_v <= trig_ld;
      if (trig_ld) begin
        s0_a  <= opnd_now;
        s0_b  <= trig_word;
        s0_op <= opcode;
      end
    end
  end

  fu_alu #(.DATA_W(DATA_W)) u_alu (
    .op(s0_op), .a(s0_a), .b(s0_b), .y(alu_y));

  fu_delay_line #(.DATA_W(DATA_W), .DEPTH(DLY)) u_dly (
    .clk(clk), .rst(rst), .in_v(s0_v), .in_d(alu_y),
    .out_v(land_v), .out_d(land_d));

  fu_result_port #(.DATA_W(DATA_W), .NUM_BUS(NUM_BUS)) u_rport (
    .clk(clk), .rst(rst), .land(land_v), .land_d(land_d),
    .rd_req(rd_req), .rd_sel(rd_sel), .bus_out(bus_out), .res_valid(res_valid));

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    trig_ld |=> s0_v);
  // R4
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_ld && opnd_ld) |=> (s0_a == opnd_q));
endmodule

// File: tb/move_trig_unit_bench.sv
module move_trig_unit_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic [31:0]  lane [4];
  logic [127:0] bus_in;
  logic [1:0]   opnd_sel, trig_sel, rd_sel;
  logic         opnd_ld, trig_ld, rd_req;
  logic [2:0]   opcode;
  logic [127:0] bus_out;
  logic         res_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [31:0] mO, p0a, p0b, p1r, mR;
  logic        p0v, p1v, mV;
  logic [2:0]  p0op;
  logic [127:0] mBus;

  always #5 clk = ~clk;
  assign bus_in = {lane[3], lane[2], lane[1], lane[0]};

  move_trig_unit u_move_trig_unit (
    .clk(clk), .rst(rst), .bus_in(bus_in), .opnd_sel(opnd_sel), .opnd_ld(opnd_ld),
    .trig_sel(trig_sel), .trig_ld(trig_ld), .opcode(opcode), .rd_req(rd_req),
    .rd_sel(rd_sel), .bus_out(bus_out), .res_valid(res_valid));

  function automatic logic [31:0] ref_op(input logic [2:0] op, input logic [31:0] o, input logic [31:0] t);
    case (op)
      3'd0: return o + t;
      3'd1: return o - t;
      3'd2: return o & t;
      3'd3: return o | t;
      3'd4: return o ^ t;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    opnd_ld = 0; trig_ld = 0; rd_req = 0;
    opnd_sel = 0; trig_sel = 0; rd_sel = 0; opcode = 0;
  endtask

  task automatic tick(input string tag);
    logic [31:0] newO;
    @(posedge clk);
    newO = opnd_ld ? lane[opnd_sel] : mO;
    mBus = '0;
    if (rd_req) mBus[rd_sel*32 +: 32] = mR;
    if (p1v) mV = 1'b1;
    else if (rd_req) mV = 1'b0;
    if (p1v) mR = p1r;
    p1v = p0v;
    p1r = ref_op(p0op, p0a, p0b);
    p0v = trig_ld;
    if (trig_ld) begin
      p0a = newO; p0b = lane[trig_sel]; p0op = opcode;
    end
    mO = newO;
    @(negedge clk);
    check({tag, " bus"}, bus_out, mBus);
    check({tag, " valid"}, {127'd0, res_valid}, {127'd0, mV});
  endtask

  // read lane sel now, return value seen on the bus one cycle later
  task automatic read_into(input logic [1:0] sel, output logic [31:0] v);
    rd_req = 1; rd_sel = sel;
    tick("R7 read");
    v = bus_out[sel*32 +: 32];
    rd_req = 0;
  endtask

  initial begin
    logic [31:0] got;
    void'($urandom(32'd4242));
    idle();
    lane[0] = 0; lane[1] = 0; lane[2] = 0; lane[3] = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mO = 0; p0a = 0; p0b = 0; p1r = 0; mR = 0; p0v = 0; p1v = 0; mV = 0; p0op = 0; mBus = 0;
    // R1
    check("R1 bus zero", bus_out, '0);
    check("R1 valid low", {127'd0, res_valid}, 128'd0);

    // R2: operand-only writes start nothing
    lane[0] = 32'h10; lane[1] = 32'h5; lane[2] = 32'h100; lane[3] = 32'hFFFF_FFFF;
    opnd_ld = 1; opnd_sel = 2;
    tick("R2 load");
    opnd_ld = 0;
    repeat (4) tick("R2 idle");
    check("R2 valid stays low", {127'd0, res_valid}, 128'd0);

    // R3/R5: add, trigger cycle k
    trig_ld = 1; trig_sel = 1; opcode = 3'd0;
    tick("R3 trigger");
    trig_ld = 0;
    tick("R3 k+1");
    read_into(2'd0, got);       // read in k+2: old contents
    check("R3 early read old", {96'd0, got}, 128'd0);
    check("R8 land+read keeps valid", {127'd0, res_valid}, 128'd1);
    read_into(2'd3, got);       // read in k+3: new result
    check("R3 read k+3", {96'd0, got}, {96'd0, 32'h105});
    check("R8 cleared by read", {127'd0, res_valid}, 128'd0);

    // R4: same-cycle operand and trigger writes, subtract
    opnd_ld = 1; opnd_sel = 0; trig_ld = 1; trig_sel = 1; opcode = 3'd1;
    tick("R4 trigger");
    idle();
    repeat (2) tick("R4 wait");
    read_into(2'd1, got);
    check("R4 new operand used", {96'd0, got}, {96'd0, 32'hB});

    // R5: every opcode
    lane[0] = 32'hF0F0_1234; lane[1] = 32'h0FF0_8765;
    opnd_ld = 1; opnd_sel = 0;
    tick("R5 load");
    idle();
    for (int op = 0; op < 8; op++) begin
      trig_ld = 1; trig_sel = 1; opcode = 3'(op);
      tick("R5 trigger");
      idle();
      repeat (2) tick("R5 wait");
      read_into(2'd2, got);
      check($sformatf("R5 opcode %0d", op), {96'd0, got},
            {96'd0, ref_op(3'(op), 32'hF0F0_1234, 32'h0FF0_8765)});
    end

    // R6: back-to-back triggers, each read in its own slot
    trig_ld = 1; trig_sel = 1; opcode = 3'd0;
    tick("R6 t0");
    opcode = 3'd4;
    tick("R6 t1");
    idle();
    tick("R6 wait");
    read_into(2'd0, got);
    check("R6 first result", {96'd0, got}, {96'd0, 32'hF0F0_1234 + 32'h0FF0_8765});
    read_into(2'd0, got);
    check("R6 second result", {96'd0, got}, {96'd0, 32'hF0F0_1234 ^ 32'h0FF0_8765});
    // R6: overwrite without reads
    for (int op = 2; op < 5; op++) begin
      trig_ld = 1; trig_sel = 1; opcode = 3'(op);
      tick("R6 burst");
    end
    idle();
    repeat (4) tick("R6 settle");
    read_into(2'd3, got);
    check("R6 last wins", {96'd0, got}, {96'd0, 32'hF0F0_1234 ^ 32'h0FF0_8765});
    check("R8 one read clears", {127'd0, res_valid}, 128'd0);

    // random moves
    for (int n = 0; n < 600; n++) begin
      for (int l = 0; l < 4; l++) lane[l] = $urandom;
      opnd_ld = 1'($urandom); opnd_sel = 2'($urandom);
      trig_ld = 1'($urandom); trig_sel = 2'($urandom);
      opcode = 3'($urandom); rd_req = 1'($urandom); rd_sel = 2'($urandom);
      tick("R7 random");
    end
    idle();
    tick("R7 end");

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule